// File: doc/BRIEF.md
# Descriptor Ring Head/Tail Controller

This block is the control side of a small circular ring of transfer descriptors that host software and a transaction engine share. Software programs where the ring lives in memory, how many entries it holds, and a head index that marks one past the newest entry it has filled. Once the run bit is set, the controller walks its own tail index toward the head. For each entry it gives the external sequencer a one-cycle start pulse, the entry index and the entry's memory address. It then waits for the sequencer's done pulse before it moves on.

Each finished descriptor reports whether it asked for an interrupt, whether it failed and whether a failure must halt the ring. The controller turns these into two sticky status flags, completion and error, which software clears by writing ones. A single interrupt line is high while either flag is set. A failure on an entry that is marked halt-on-failure freezes the tail on that entry and drops the run bit, so software can inspect the entry and restart.

The descriptor memory and the sequencer are outside this block. Software reaches the block through a flat word-addressed register port with a combinational read path.

Top module: `desc_ring_ctl`

## Requirements
- R1: After reset every register reads zero, the tail is 0, the in-progress bit is 0, `irq` is 0 and `seq_start` is 0.
- R2: The control register at offset 0x08 holds the run bit at bit 0, the error-interrupt enable at bit 4 and the head index in bits 23:16. All three read back as written.
- R3: The status register at offset 0x0C shows in-progress at bit 0, the error flag at bit 4, the completion flag at bit 5 and the tail index in bits 23:16.
- R4: The low 8 bits of the size register at offset 0x10 hold the number of entries minus one. The tail steps from that index back to 0.
- R5: The ring base is a 64-bit address, with the low word at offset 0x00 and the high word at offset 0x04. `seq_addr` equals base + 16 × `seq_index`.
- R6: With the run bit set and tail different from head, `seq_start` pulses for one cycle in the cycle after the decision, with `seq_index` equal to the tail. The tail advances on each done. The next pulse follows the done by one cycle while tail still differs from head, and in-progress clears when they are equal. No descriptor is issued while the run bit is 0.
- R7: A done with `seq_want_irq` set sets the completion flag. Writing 1 to bit 5 of status clears it, and writing 0 leaves it unchanged.
- R8: A done with `seq_fail` set sets the error flag only when the error-interrupt enable is 1. Writing 1 to bit 4 of status clears it.
- R9: `irq` is 1 exactly while the completion flag or the error flag is set.
- R10: A failed done with `seq_stop_on_err` set leaves the tail on that entry, clears in-progress and the run bit, and issues nothing more until software sets the run bit again.
- R11: Writing the head index while a descriptor is running issues nothing new and keeps `seq_index` steady. The new head is used at the next comparison, after the done.
- R12: A done pulse while no descriptor is running changes neither the tail nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset for register write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 1 | Interrupt, high while either status flag is set |
| seq_start | output | 1 | One-cycle pulse that hands a descriptor to the sequencer |
| seq_index | output | 8 | Ring index of the descriptor being run |
| seq_addr | output | 64 | Memory address of the descriptor being run |
| seq_done | input | 1 | Sequencer finished the current descriptor |
| seq_fail | input | 1 | With done: the descriptor failed |
| seq_want_irq | input | 1 | With done: the descriptor asked for a completion interrupt |
| seq_stop_on_err | input | 1 | With done: a failure must halt the ring |

## Verification
A tail that steps wrongly shows up at once as a wrong `seq_index` and `seq_addr` on the next start pulse. It also shows in the tail field of status as soon as the batch drains. A walker stuck in the running state never issues the next pulse, so the bench's wait for the pulse expires within twenty cycles. A wrong flag update shows on `irq` in the cycle after the done or the clearing write. A run bit that survives a halting failure shows as an extra start pulse within a few cycles.

// File: rtl/desc_ring_ctl_pkg.sv
package desc_ring_ctl_pkg;

    localparam int REG_AW = 5;

    // register offsets
    localparam logic [REG_AW-1:0] OFS_BASE_LO = 5'h00;
    localparam logic [REG_AW-1:0] OFS_BASE_HI = 5'h04;
    localparam logic [REG_AW-1:0] OFS_CTRL    = 5'h08;
    localparam logic [REG_AW-1:0] OFS_STAT    = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_SIZE    = 5'h10;

    // bit positions that software decodes
    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_EIE_BIT  = 4;
    localparam int PTR_FIELD_LSB = 16;
    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_ERR_BIT  = 4;
    localparam int STAT_CMPL_BIT = 5;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_WAIT = 1'b1
    } walk_state_e;

endpackage

// File: rtl/ring_walker.sv
module ring_walker
    import desc_ring_ctl_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [PTR_W-1:0] head_i,
    input  logic [PTR_W-1:0] last_idx_i,
    input  logic             done_i,
    input  logic             fail_i,
    input  logic             want_irq_i,
    input  logic             stop_on_err_i,
    output logic             issue_o,
    output logic [PTR_W-1:0] tail_o,
    output logic             busy_o,
    output logic             halt_o,
    output logic             cmpl_evt_o,
    output logic             fail_evt_o
);

    typedef struct packed {
        walk_state_e      state;
        logic [PTR_W-1:0] tail;
        logic             issue;
    } walk_t;

    walk_t            w_d, w_q;
    logic [PTR_W-1:0] tail_next;
    logic             halt_d;
    logic             cmpl_d;
    logic             fail_d;

    always_comb begin
        tail_next = (w_q.tail == last_idx_i) ? '0 : w_q.tail + 1'b1;
        w_d       = w_q;
        w_d.issue = 1'b0;
        halt_d    = 1'b0;
        cmpl_d    = 1'b0;
        fail_d    = 1'b0;
        unique case (w_q.state)
            WALK_IDLE: begin
                if (run_i && (w_q.tail != head_i)) begin
                    w_d.state = WALK_WAIT;
                    w_d.issue = 1'b1;
                end
            end
            WALK_WAIT: begin
                if (done_i) begin
                    cmpl_d = want_irq_i;
                    fail_d = fail_i;
                    if (fail_i && stop_on_err_i) begin
                        halt_d    = 1'b1;
                        w_d.state = WALK_IDLE;
                    end else begin
                        w_d.tail = tail_next;
                        if (run_i && (tail_next != head_i)) begin
                            w_d.issue = 1'b1;
                        end else begin
                            w_d.state = WALK_IDLE;
                        end
                    end
                end
            end
            default: w_d.state = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '{state: WALK_IDLE, tail: '0, issue: 1'b0};
        end else begin
            w_q <= w_d;
        end
    end

    assign issue_o    = w_q.issue;
    assign tail_o     = w_q.tail;
    assign busy_o     = (w_q.state == WALK_WAIT);
    assign halt_o     = halt_d;
    assign cmpl_evt_o = cmpl_d;
    assign fail_evt_o = fail_d;

    // R6: the tail only moves after a done accepted while running
    assert_tail_moves_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.tail != $past(w_q.tail)) |-> ($past(done_i) && $past(w_q.state == WALK_WAIT)));

    // R10: a halting failure freezes the tail and drops to idle
    assert_halt_freezes_tail_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.state == WALK_WAIT && done_i && fail_i && stop_on_err_i)
            |=> (w_q.tail == $past(w_q.tail) && w_q.state == WALK_IDLE));

    // R11: a new issue only follows an idle cycle or a done, never a head write mid-run
    assert_issue_after_idle_or_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.issue |-> ($past(w_q.state == WALK_IDLE) || $past(done_i)));

    // R12: done while idle leaves the tail alone
    assert_idle_done_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.state == WALK_IDLE && done_i) |=> (w_q.tail == $past(w_q.tail)));

endmodule

// File: rtl/ring_regs.sv
module ring_regs
    import desc_ring_ctl_pkg::*;
#(
    parameter int PTR_W  = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              busy_i,
    input  logic [PTR_W-1:0]  tail_i,
    input  logic              halt_i,
    input  logic              cmpl_evt_i,
    input  logic              fail_evt_i,
    output logic              run_o,
    output logic [PTR_W-1:0]  head_o,
    output logic [PTR_W-1:0]  last_idx_o,
    output logic [ADDR_W-1:0] base_o,
    output logic              irq_o
);

    localparam int HI_W = ADDR_W - DATA_W;

    typedef struct packed {
        logic              run;
        logic              eie;
        logic [PTR_W-1:0]  head;
        logic [PTR_W-1:0]  last_idx;
        logic [ADDR_W-1:0] base;
        logic              cmpl;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en_i) begin
            unique case (addr_i)
                OFS_BASE_LO: r_d.base[DATA_W-1:0] = wdata_i;
                OFS_BASE_HI: r_d.base[ADDR_W-1:DATA_W] = wdata_i[HI_W-1:0];
                OFS_CTRL: begin
                    r_d.run  = wdata_i[CTRL_RUN_BIT];
                    r_d.eie  = wdata_i[CTRL_EIE_BIT];
                    r_d.head = wdata_i[PTR_FIELD_LSB +: PTR_W];
                end
                OFS_STAT: begin
                    if (wdata_i[STAT_CMPL_BIT]) r_d.cmpl = 1'b0;
                    if (wdata_i[STAT_ERR_BIT])  r_d.err  = 1'b0;
                end
                OFS_SIZE: r_d.last_idx = wdata_i[PTR_W-1:0];
                default: ;
            endcase
        end
        // hardware events win over a same-cycle software write
        if (cmpl_evt_i)              r_d.cmpl = 1'b1;
        if (fail_evt_i && r_q.eie)   r_d.err  = 1'b1;
        if (halt_i)                  r_d.run  = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            OFS_BASE_LO: rdata_o = r_q.base[DATA_W-1:0];
            OFS_BASE_HI: rdata_o[HI_W-1:0] = r_q.base[ADDR_W-1:DATA_W];
            OFS_CTRL: begin
                rdata_o[CTRL_RUN_BIT]              = r_q.run;
                rdata_o[CTRL_EIE_BIT]              = r_q.eie;
                rdata_o[PTR_FIELD_LSB +: PTR_W]    = r_q.head;
            end
            OFS_STAT: begin
                rdata_o[STAT_BUSY_BIT]             = busy_i;
                rdata_o[STAT_ERR_BIT]              = r_q.err;
                rdata_o[STAT_CMPL_BIT]             = r_q.cmpl;
                rdata_o[PTR_FIELD_LSB +: PTR_W]    = tail_i;
            end
            OFS_SIZE: rdata_o[PTR_W-1:0] = r_q.last_idx;
            default: rdata_o = '0;
        endcase
    end

    assign run_o      = r_q.run;
    assign head_o     = r_q.head;
    assign last_idx_o = r_q.last_idx;
    assign base_o     = r_q.base;
    assign irq_o      = r_q.cmpl | r_q.err;

    // R8: the error flag never rises unless the enable was set
    assert_err_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.err) |-> $past(r_q.eie));

    // R7: a write of 1 to the completion bit clears it when no new completion arrives
    assert_cmpl_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == OFS_STAT && wdata_i[STAT_CMPL_BIT] && !cmpl_evt_i) |=> !r_q.cmpl);

    // R10: a halt from the walker drops the run bit
    assert_halt_clears_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> !r_q.run);

    // R9: the interrupt line drops only after a clearing write
    assert_irq_falls_on_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(wr_en_i && addr_i == OFS_STAT));

endmodule

// File: rtl/desc_ring_ctl.sv
module desc_ring_ctl
    import desc_ring_ctl_pkg::*;
#(
    parameter int PTR_W            = 8,
    parameter int DATA_W           = 32,
    parameter int ADDR_W           = 64,
    parameter int ENTRY_BYTES_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              seq_start,
    output logic [PTR_W-1:0]  seq_index,
    output logic [ADDR_W-1:0] seq_addr,
    input  logic              seq_done,
    input  logic              seq_fail,
    input  logic              seq_want_irq,
    input  logic              seq_stop_on_err
);

    localparam int OFS_W = PTR_W + ENTRY_BYTES_LOG2;

    logic              run;
    logic [PTR_W-1:0]  head;
    logic [PTR_W-1:0]  last_idx;
    logic [ADDR_W-1:0] base;
    logic [PTR_W-1:0]  tail;
    logic              busy;
    logic              halt;
    logic              cmpl_evt;
    logic              fail_evt;
    logic [OFS_W-1:0]  entry_ofs;

    ring_regs #(
        .PTR_W (PTR_W),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (reg_wr_en),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .rdata_o   (reg_rdata),
        .busy_i    (busy),
        .tail_i    (tail),
        .halt_i    (halt),
        .cmpl_evt_i(cmpl_evt),
        .fail_evt_i(fail_evt),
        .run_o     (run),
        .head_o    (head),
        .last_idx_o(last_idx),
        .base_o    (base),
        .irq_o     (irq)
    );

    ring_walker #(
        .PTR_W(PTR_W)
    ) walker_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run),
        .head_i       (head),
        .last_idx_i   (last_idx),
        .done_i       (seq_done),
        .fail_i       (seq_fail),
        .want_irq_i   (seq_want_irq),
        .stop_on_err_i(seq_stop_on_err),
        .issue_o      (seq_start),
        .tail_o       (tail),
        .busy_o       (busy),
        .halt_o       (halt),
        .cmpl_evt_o   (cmpl_evt),
        .fail_evt_o   (fail_evt)
    );

    assign entry_ofs = {tail, {ENTRY_BYTES_LOG2{1'b0}}};
    assign seq_index = tail;
    assign seq_addr  = base + ADDR_W'(entry_ofs);

    // R6: a start pulse lasts one cycle unless a done chains the next entry
    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_start && !seq_done) |=> !seq_start);

endmodule

// File: tb/desc_ring_ctl_tb.sv
module desc_ring_ctl_tb_top;

    // time unit is 1 ps: 5000 ps period gives 200 MHz
    localparam int HALF = 2500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        seq_start;
    logic [7:0]  seq_index;
    logic [63:0] seq_addr;
    logic        seq_done = 1'b0;
    logic        seq_fail = 1'b0;
    logic        seq_want_irq = 1'b0;
    logic        seq_stop_on_err = 1'b0;

    int checks = 0;
    int errors = 0;

    // bench model
    logic [7:0]  tail_m = '0;
    logic [7:0]  last_m = '0;
    logic        eie_m = 1'b0;
    logic        cmpl_m = 1'b0;
    logic        err_m = 1'b0;
    logic [63:0] base_m = '0;

    always #HALF clk = ~clk;

    desc_ring_ctl dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_wr_en      (reg_wr_en),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .irq            (irq),
        .seq_start      (seq_start),
        .seq_index      (seq_index),
        .seq_addr       (seq_addr),
        .seq_done       (seq_done),
        .seq_fail       (seq_fail),
        .seq_want_irq   (seq_want_irq),
        .seq_stop_on_err(seq_stop_on_err)
    );

    function automatic logic [31:0] ctrl_word(input logic run, input logic eie, input logic [7:0] head);
        return {8'h00, head, 11'd0, eie, 3'd0, run};
    endfunction

    function automatic logic [31:0] stat_word(input logic busy, input logic err, input logic cmpl,
                                              input logic [7:0] tail);
        return {8'h00, tail, 10'd0, cmpl, err, 3'd0, busy};
    endfunction

    function automatic logic [7:0] step(input logic [7:0] t, input logic [7:0] last);
        return (t == last) ? 8'd0 : t + 8'd1;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #100;
        d = reg_rdata;
    endtask

    task automatic wait_issue(input string tag);
        int n = 0;
        while (!seq_start && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " start pulse"}, 64'(seq_start), 64'd1);
        chk({tag, " index"}, 64'(seq_index), 64'(tail_m));
        chk("R5 descriptor address", seq_addr, base_m + 64'(tail_m) * 64'd16);
    endtask

    task automatic finish_desc(input logic want_irq, input logic fail, input logic stop);
        seq_done        = 1'b1;
        seq_want_irq    = want_irq;
        seq_fail        = fail;
        seq_stop_on_err = stop;
        @(negedge clk);
        seq_done        = 1'b0;
        seq_want_irq    = 1'b0;
        seq_fail        = 1'b0;
        seq_stop_on_err = 1'b0;
        if (want_irq) cmpl_m = 1'b1;
        if (fail && eie_m) err_m = 1'b1;
        if (!(fail && stop)) tail_m = step(tail_m, last_m);
    endtask

    task automatic check_status(input string tag);
        logic [31:0] v;
        reg_read(5'h0C, v);
        chk({tag, " status"}, 64'(v), 64'(stat_word(1'b0, err_m, cmpl_m, tail_m)));
        chk("R9 irq level", 64'(irq), 64'(cmpl_m | err_m));
    endtask

    task automatic clear_flags();
        reg_write(5'h0C, 32'h0000_0030);
        cmpl_m = 1'b0;
        err_m  = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(5'h08, v); chk("R1 ctrl after reset", 64'(v), 64'd0);
        reg_read(5'h0C, v); chk("R1 status after reset", 64'(v), 64'd0);
        reg_read(5'h10, v); chk("R1 size after reset", 64'(v), 64'd0);
        reg_read(5'h00, v); chk("R1 base after reset", 64'(v), 64'd0);
        chk("R1 irq after reset", 64'(irq), 64'd0);
        chk("R1 start after reset", 64'(seq_start), 64'd0);

        // R5 base, R4 size, R2 control fields
        reg_write(5'h00, 32'h8000_1230);
        reg_write(5'h04, 32'h0000_00A5);
        base_m = 64'h0000_00A5_8000_1230;
        reg_read(5'h00, v); chk("R5 base low", 64'(v), 64'h8000_1230);
        reg_read(5'h04, v); chk("R5 base high", 64'(v), 64'hA5);
        reg_write(5'h10, 32'd3); last_m = 8'd3;
        reg_read(5'h10, v); chk("R4 size", 64'(v), 64'd3);
        reg_write(5'h08, ctrl_word(1'b0, 1'b1, 8'd2)); eie_m = 1'b1;
        reg_read(5'h08, v); chk("R2 ctrl readback", 64'(v), 64'(ctrl_word(1'b0, 1'b1, 8'd2)));

        // R6 nothing issued while run bit is 0
        repeat (4) @(negedge clk);
        chk("R6 no issue without run", 64'(seq_start), 64'd0);
        check_status("R6 idle without run");

        // R6 R3 R7 two entries, second asks for an interrupt
        reg_write(5'h08, ctrl_word(1'b1, 1'b1, 8'd2));
        wait_issue("R6 first");
        finish_desc(1'b0, 1'b0, 1'b0);
        wait_issue("R6 chained");
        finish_desc(1'b1, 1'b0, 1'b0);
        check_status("R3 after batch");
        reg_write(5'h0C, 32'h0);
        check_status("R7 write zero keeps flag");
        clear_flags();
        check_status("R7 write one clears");

        // R4 wrap 2,3,0
        reg_write(5'h08, ctrl_word(1'b1, 1'b1, 8'd1));
        for (int i = 0; i < 3; i++) begin
            wait_issue("R4 wrap");
            finish_desc(1'b0, 1'b0, 1'b0);
        end
        check_status("R4 tail after wrap");

        // R8 error with enable
        reg_write(5'h08, ctrl_word(1'b1, 1'b1, 8'd2));
        wait_issue("R8 enabled");
        finish_desc(1'b0, 1'b1, 1'b0);
        check_status("R8 error flagged");
        clear_flags();
        check_status("R8 error cleared");

        // R8 error with enable off
        reg_write(5'h08, ctrl_word(1'b1, 1'b0, 8'd3)); eie_m = 1'b0;
        wait_issue("R8 disabled");
        finish_desc(1'b0, 1'b1, 1'b0);
        check_status("R8 error masked");

        // R10 halting failure at entry 3
        reg_write(5'h08, ctrl_word(1'b1, 1'b1, 8'd1)); eie_m = 1'b1;
        wait_issue("R10 first");
        finish_desc(1'b0, 1'b1, 1'b1);
        repeat (4) @(negedge clk);
        chk("R10 no issue after halt", 64'(seq_start), 64'd0);
        check_status("R10 halted");
        reg_read(5'h08, v); chk("R10 run bit cleared", 64'(v), 64'(ctrl_word(1'b0, 1'b1, 8'd1)));
        clear_flags();
        reg_write(5'h08, ctrl_word(1'b1, 1'b1, 8'd1));
        for (int i = 0; i < 2; i++) begin
            wait_issue("R10 restart");
            finish_desc(1'b0, 1'b0, 1'b0);
        end
        check_status("R10 after restart");

        // R11 head write while running
        reg_write(5'h08, ctrl_word(1'b1, 1'b1, 8'd2));
        wait_issue("R11 running");
        reg_write(5'h08, ctrl_word(1'b1, 1'b1, 8'd3));
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R11 no extra issue", 64'(seq_start), 64'd0);
            chk("R11 index steady", 64'(seq_index), 64'd1);
        end
        finish_desc(1'b0, 1'b0, 1'b0);
        wait_issue("R11 new head used");
        finish_desc(1'b0, 1'b0, 1'b0);
        check_status("R11 drained");

        // R12 done while idle
        repeat (2) @(negedge clk);
        seq_done = 1'b1; seq_want_irq = 1'b1; seq_fail = 1'b1;
        @(negedge clk);
        seq_done = 1'b0; seq_want_irq = 1'b0; seq_fail = 1'b0;
        check_status("R12 idle done ignored");

        // random batches over a six-entry ring
        reg_write(5'h10, 32'd5); last_m = 8'd5;
        for (int b = 0; b < 30; b++) begin
            int n;
            logic [7:0] h;
            logic e;
            n = 1 + int'($urandom % 5);
            h = tail_m;
            for (int k = 0; k < n; k++) h = step(h, last_m);
            e = 1'($urandom % 2);
            eie_m = e;
            reg_write(5'h08, ctrl_word(1'b1, e, h));
            for (int k = 0; k < n; k++) begin
                logic wi, fl;
                wi = 1'($urandom % 2);
                fl = (($urandom % 4) == 0);
                wait_issue("R6 random");
                finish_desc(wi, fl, 1'b0);
            end
            check_status("R3 random batch");
            clear_flags();
            chk("R9 irq after clear", 64'(irq), 64'd0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule